// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by reading one descriptor from a flat page table in memory. A request carries a virtual address and a write flag. The upper bits of the address select a page. The lower bits are the byte offset within that page. The block adds the page index, scaled by the descriptor size, to a table base input. It reads the descriptor at that address through a simple memory port and decodes it.

On a hit, the block sets the use bit in the descriptor. On a write hit it also sets the dirty bit. It writes the updated descriptor back to the same address and then returns the frame number joined to the unchanged offset. If the page is absent, or if a write targets a read-only page, no write-back takes place. The block returns a fault status instead of an address.

Requests and responses are valid/ready streams. The block handles one request at a time. `req_ready` is high only when the block is idle. A response stays on the outputs, unchanged, until `rsp_ready` is seen high. A memory request stays unchanged until `mem_req_ready` is high.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the block is idle. It drops in the cycle after a request is accepted and stays low until the response is taken. While it is high, neither `mem_req_valid` nor `rsp_valid` is asserted.
- R2: The descriptor read (`mem_req_we`=0) goes to address `ptbr + vpn*DESC_BYTES`. The base value is captured when the request is accepted.
- R3: When descriptor bit 0 (present) is 1 and the access is allowed, `rsp_status` is 0 (ok). `rsp_paddr` is then the frame number in descriptor bits [4 +: PFN_W], concatenated above the unchanged offset.
- R4: On a hit, the descriptor is written back (`mem_req_we`=1) to the same address. Bit 2 (use) is set. Bit 1 (dirty) is set when the access is a write. All other bits keep their values.
- R5: When the present bit is 0, `rsp_status` is 1 (page fault), `rsp_paddr` is 0, `rsp_vpn` holds the faulting page, and no write-back is made.
- R6: A write to a page whose descriptor bit 3 (writable) is 0 gives `rsp_status` 2 (protection fault) and no write-back. A read of the same page translates normally.
- R7: The write-back of a hit is accepted by the memory before `rsp_valid` rises.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_status` hold their values.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request and its address and direction hold.
- R10: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | MA_W | Byte base address of the page table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_write | input | 1 | 1 for a write access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_paddr | output | PFN_W+OFF_W | Physical address (0 on a fault) |
| rsp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_vpn | output | VPN_W | Page number of the request |
| mem_req_valid | output | 1 | Memory access valid |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_we | output | 1 | 1 write-back, 0 descriptor read |
| mem_req_addr | output | MA_W | Descriptor byte address |
| mem_req_wdata | output | DESC_W | Updated descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DESC_W | Descriptor read data |

## Verification
The bench translates reads and writes to writable pages and to read-only pages, and a request to an absent page. These patterns separate the three status codes and show which use and dirty bits each access sets. The table base is moved to a second table, which shows that the base value and the scaling are used rather than a fixed location. Runs with a stalled memory port and a held-off response check that the address, the direction and the result stay stable. The count of memory writes, sampled when the result appears, shows that the write-back comes first on a hit and that no write takes place on a fault.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    XL_OK         = 2'd0,
    XL_PAGE_FAULT = 2'd1,
    XL_PROT_FAULT = 2'd2
  } xl_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WB_REQ, S_RESP
  } walk_state_e;

  // descriptor bit positions
  localparam int unsigned DB_PRESENT = 0;
  localparam int unsigned DB_DIRTY   = 1;
  localparam int unsigned DB_USE     = 2;
  localparam int unsigned DB_WRITE   = 3;
  localparam int unsigned DB_PFN_LSB = 4;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned VPN_W      = 2,
  parameter int unsigned MA_W       = 16,
  parameter int unsigned DESC_BYTES = 4
) (
  input  logic [MA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [MA_W-1:0]  desc_addr
);
  localparam int unsigned SCALE_SH = $clog2(DESC_BYTES);

  logic [MA_W-1:0] scaled;

  always_comb begin
    scaled    = MA_W'(vpn) << SCALE_SH;
    desc_addr = base + scaled;
  end
endmodule

// File: rtl/pt_desc_eval.sv
module pt_desc_eval
  import pt_pkg::*;
#(
  parameter int unsigned DESC_W = 16,
  parameter int unsigned PFN_W  = 1,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [DESC_W-1:0]      desc,
  input  logic                   is_write,
  input  logic [OFF_W-1:0]       offset,
  output xl_status_e             status,
  output logic [PFN_W+OFF_W-1:0] paddr,
  output logic [DESC_W-1:0]      desc_upd
);
  logic [PFN_W-1:0] pfn;

  always_comb begin
    pfn      = desc[DB_PFN_LSB +: PFN_W];
    desc_upd = desc;
    paddr    = '0;
    if (!desc[DB_PRESENT]) begin
      status = XL_PAGE_FAULT;
    end else if (is_write && !desc[DB_WRITE]) begin
      status = XL_PROT_FAULT;
    end else begin
      status           = XL_OK;
      paddr            = {pfn, offset};
      desc_upd[DB_USE] = 1'b1;
      if (is_write) desc_upd[DB_DIRTY] = 1'b1;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int unsigned VPN_W      = 2,
  parameter int unsigned OFF_W      = 10,
  parameter int unsigned PFN_W      = 1,
  parameter int unsigned MA_W       = 16,
  parameter int unsigned DESC_W     = 16,
  parameter int unsigned DESC_BYTES = 4,
  localparam int unsigned VA_W      = VPN_W + OFF_W,
  localparam int unsigned PA_W      = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MA_W-1:0]   ptbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_status,
  output logic [VPN_W-1:0]  rsp_vpn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [MA_W-1:0]   mem_req_addr,
  output logic [DESC_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_rdata
);
  walk_state_e       state;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic [MA_W-1:0]   addr_q;
  logic [DESC_W-1:0] desc_q;
  logic [PA_W-1:0]   paddr_q;
  xl_status_e        status_q;

  logic [MA_W-1:0]   desc_addr;
  xl_status_e        ev_status;
  logic [PA_W-1:0]   ev_paddr;
  logic [DESC_W-1:0] ev_desc;

  pt_addr_gen #(
    .VPN_W(VPN_W), .MA_W(MA_W), .DESC_BYTES(DESC_BYTES)
  ) u_addr (
    .base(ptbr), .vpn(req_vaddr[VA_W-1 -: VPN_W]), .desc_addr(desc_addr)
  );

  pt_desc_eval #(
    .DESC_W(DESC_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
  ) u_eval (
    .desc(mem_rsp_rdata), .is_write(write_q), .offset(vaddr_q[OFF_W-1:0]),
    .status(ev_status), .paddr(ev_paddr), .desc_upd(ev_desc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      vaddr_q  <= '0;
      write_q  <= 1'b0;
      addr_q   <= '0;
      desc_q   <= '0;
      paddr_q  <= '0;
      status_q <= XL_OK;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          write_q <= req_write;
          addr_q  <= desc_addr;
          state   <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          desc_q   <= ev_desc;
          paddr_q  <= ev_paddr;
          status_q <= ev_status;
          state    <= (ev_status == XL_OK) ? S_WB_REQ : S_RESP;
        end
        S_WB_REQ: if (mem_req_ready) state <= S_RESP;
        S_RESP:   if (rsp_ready) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == S_IDLE);
    mem_req_valid = (state == S_RD_REQ) || (state == S_WB_REQ);
    mem_req_we    = (state == S_WB_REQ);
    mem_req_addr  = addr_q;
    mem_req_wdata = desc_q;
    rsp_valid     = (state == S_RESP);
    rsp_paddr     = paddr_q;
    rsp_status    = status_q;
    rsp_vpn       = vaddr_q[VA_W-1 -: VPN_W];
  end

  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);                          // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);                               // R1
  AST_WB_SETS_USE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[DB_USE] && mem_req_wdata[DB_PRESENT]); // R4
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status != XL_OK |-> rsp_paddr == '0);                // R5
  AST_WB_BEFORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_status == XL_OK |-> $past(mem_req_valid && mem_req_we && mem_req_ready)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)); // R8
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R9
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ptbr = 16'h0040;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [11:0] req_vaddr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [10:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic [1:0]  rsp_vpn;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;

  logic [15:0] mem [64];
  int          wr_count = 0;
  logic        mem_stall = 1'b0;
  logic        poke_en = 1'b0;
  logic [5:0]  poke_idx = '0;
  logic [15:0] poke_data = '0;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;
  assign mem_req_ready = !mem_stall;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_status(rsp_status), .rsp_vpn(rsp_vpn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (poke_en) mem[poke_idx] <= poke_data;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[7:2]] <= mem_req_wdata;
        wr_count <= wr_count + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[7:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [5:0] idx, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = idx; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // issues one translation and returns what was seen when rsp_valid first appeared
  task automatic xlate(input logic [11:0] va, input logic wr, input int stall_n, input int hold_n,
                       input logic [15:0] exp_daddr,
                       output logic [10:0] pa, output logic [1:0] st, output logic [1:0] vpn,
                       output int wr_seen);
    @(negedge clk);
    mem_stall = (stall_n > 0);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 ready low after accept", 32'(req_ready), 32'd0);
    if (stall_n > 0) begin
      for (int i = 0; i < stall_n; i++) begin
        chk("R9 read held under stall", 32'(mem_req_valid && !mem_req_we), 32'd1);
        chk("R2 descriptor address", 32'(mem_req_addr), 32'(exp_daddr));
        @(negedge clk);
      end
      mem_stall = 1'b0;
    end else begin
      chk("R2 descriptor address", 32'(mem_req_addr), 32'(exp_daddr));
    end
    while (!rsp_valid) begin
      if (req_ready) chk("R1 ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    pa = rsp_paddr; st = rsp_status; vpn = rsp_vpn; wr_seen = wr_count;
    for (int i = 0; i < hold_n; i++) begin
      @(negedge clk);
      chk("R8 response held", {rsp_valid, rsp_status, 18'd0, rsp_paddr}, {1'b1, st, 18'd0, pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1 ready back after response", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    chk("R10 reset req_ready", 32'(req_ready), 32'd1);
    chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_read_hit();
    logic [10:0] pa; logic [1:0] st, vp; int w0, ws;
    w0 = wr_count;
    xlate(12'h555, 1'b0, 0, 0, 16'h0044, pa, st, vp, ws);
    chk("R3 read hit status", 32'(st), 32'd0);
    chk("R3 read hit paddr", 32'(pa), 32'h555);
    chk("R7 write-back before result", 32'(ws - w0), 32'd1);
    chk("R4 use bit set on read", 32'(mem[17]), 32'h001D);
  endtask

  task automatic t_write_hit();
    logic [10:0] pa; logic [1:0] st, vp; int w0, ws;
    w0 = wr_count;
    xlate(12'hFFF, 1'b1, 0, 0, 16'h004C, pa, st, vp, ws);
    chk("R3 write hit paddr", 32'(pa), 32'h3FF);
    chk("R7 write-back before result", 32'(ws - w0), 32'd1);
    chk("R4 use and dirty set on write", 32'(mem[19]), 32'h000F);
  endtask

  task automatic t_page_fault();
    logic [10:0] pa; logic [1:0] st, vp; int w0, ws;
    w0 = wr_count;
    xlate(12'h012, 1'b1, 0, 2, 16'h0040, pa, st, vp, ws);
    @(negedge clk);
    chk("R5 page fault status", 32'(st), 32'd1);
    chk("R5 page fault paddr", 32'(pa), 32'd0);
    chk("R5 page fault vpn", 32'(vp), 32'd0);
    chk("R5 no write on fault", 32'(wr_count - w0), 32'd0);
    chk("R5 descriptor untouched", 32'(mem[16]), 32'hA500);
  endtask

  task automatic t_protection();
    logic [10:0] pa; logic [1:0] st, vp; int w0, ws;
    w0 = wr_count;
    xlate(12'hAA0, 1'b1, 0, 0, 16'h0048, pa, st, vp, ws);
    @(negedge clk);
    chk("R6 protection fault status", 32'(st), 32'd2);
    chk("R6 protection fault vpn", 32'(vp), 32'd2);
    chk("R6 no write on protection fault", 32'(wr_count - w0), 32'd0);
    chk("R6 read-only descriptor untouched", 32'(mem[18]), 32'h0001);
    xlate(12'hAA0, 1'b0, 0, 3, 16'h0048, pa, st, vp, ws);
    chk("R6 read of read-only page ok", 32'(st), 32'd0);
    chk("R3 read-only page paddr", 32'(pa), 32'h2A0);
    chk("R4 use only on read-only page", 32'(mem[18]), 32'h0005);
  endtask

  task automatic t_stall_and_rehit();
    logic [10:0] pa; logic [1:0] st, vp; int w0, ws;
    w0 = wr_count;
    xlate(12'h401, 1'b1, 4, 2, 16'h0044, pa, st, vp, ws);
    chk("R3 stalled write paddr", 32'(pa), 32'h401);
    chk("R7 write-back before result (stall)", 32'(ws - w0), 32'd1);
    chk("R4 dirty added, rest kept", 32'(mem[17]), 32'h001F);
  endtask

  task automatic t_new_base();
    logic [10:0] pa; logic [1:0] st, vp; int ws;
    poke(6'd33, 16'h0001);
    @(negedge clk);
    ptbr = 16'h0080;
    xlate(12'h4AB, 1'b0, 0, 0, 16'h0084, pa, st, vp, ws);
    chk("R2 new table paddr", 32'(pa), 32'h0AB);
    chk("R2 new table descriptor updated", 32'(mem[33]), 32'h0005);
    chk("R2 old table untouched", 32'(mem[17]), 32'h001F);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // descriptor: bit0 present, bit1 dirty, bit2 use, bit3 writable, bit4 frame, [15:8] disk tag
    poke(6'd16, 16'hA500);
    poke(6'd17, 16'h0019);
    poke(6'd18, 16'h0001);
    poke(6'd19, 16'h0009);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_page_fault();
    t_protection();
    t_stall_and_rehit();
    t_new_base();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule